// File: doc/BRIEF.md
# I2C register-port target

This block is a two-wire serial target that lets a host controller read and write a bank of 128 eight-bit registers held inside it. The clock and data lines arrive as plain inputs sampled by the system clock. The block drives the data line only by pulling it low, through a single drive-enable output. It detects bus start and stop conditions, compares the seven-bit device address against its own, and acknowledges every byte it accepts.

A write transfer carries a pointer byte first. The low seven bits of that byte select a register, and its top bit enables stepping the pointer after each access. The data bytes that follow are stored through the pointer. A read transfer streams register contents out from wherever the pointer was left, so a read placed after a write, with or without an intervening stop, continues from the stepped position. A side port gives direct access to the bank, so the bank can be preloaded and inspected without the bus.

Top module: `i2c_regport`

## Requirements
- R1: The first byte after a start is seven address bits, most significant bit first, followed by a direction bit (1 read, 0 write). When the address equals 1001010 binary, the block pulls SDA low during the ninth clock.
- R2: When the address differs, SDA stays released for the rest of the transfer, and no register changes.
- R3: In a write, the byte after the address is the pointer byte. Bits 6..0 load the pointer and bit 7 loads the auto-increment enable. The pointer byte is acknowledged.
- R4: Each later write byte is stored at the pointer and acknowledged. With auto-increment on, the pointer then advances by one.
- R5: With auto-increment off, the pointer does not move, so every data byte lands in the same register.
- R6: An increment from register 127 wraps the pointer to register 0.
- R7: A read sends the register at the pointer, most significant bit first, and then advances the pointer when auto-increment is on. After n bytes are written starting at X, a read begins at X+n.
- R8: A host NACK after a read byte ends the read, and SDA stays released until the next start or stop. A stop or a repeated start leaves the pointer and the auto-increment enable unchanged.
- R9: Both lines pass through a two-flop synchronizer. The block changes its SDA drive only while SCL is low, and it presents each read bit after the falling edge of SCL.
- R10: After reset, SDA is released, every register is 0, the pointer is 0 and auto-increment is off.
- R11: The side port writes the register at its address on a clock edge when its write enable is high. It always returns the contents of the register at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| tap_we_i | input | 1 | Side-port write enable |
| tap_addr_i | input | 7 | Side-port register address |
| tap_wdata_i | input | 8 | Side-port write data |
| tap_rdata_o | output | 8 | Side-port read data for tap_addr_i |

## Verification
The assertions rely on a well-formed host. The host changes SDA only while SCL is low, except when it forms a start or a stop. It never issues a start or a stop while the target is pulling SDA low. Each SCL phase lasts longer than the synchronizer delay. The stimulus holds every SCL phase for twenty system clocks and moves host data ten clocks into the low phase. It issues stops only after a write acknowledge or a host NACK, and it forms repeated starts only after the target has released the line.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } port_state_e;

    typedef struct packed {
        port_state_e        state;
        port_state_e        after;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [PTR_W-1:0]   ptr;
        logic               incr;
        logic               oe;
        logic               nack;
    } port_regs_t;

    localparam port_regs_t PORT_RST = '{
        state: ST_IDLE,
        after: ST_IDLE,
        cnt:   '0,
        sh:    '0,
        ptr:   '0,
        incr:  1'b0,
        oe:    1'b0,
        nack:  1'b0
    };
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], line_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= pipe_d;
    end

    assign lvl_o  = pipe_q[STAGES-1];
    assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bus_we_i,
    input  logic [AW-1:0] bus_waddr_i,
    input  logic [DW-1:0] bus_wdata_i,
    input  logic [AW-1:0] bus_raddr_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic          tap_we_i,
    input  logic [AW-1:0] tap_addr_i,
    input  logic [DW-1:0] tap_wdata_i,
    output logic [DW-1:0] tap_rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (tap_we_i) mem_d[tap_addr_i]  = tap_wdata_i;
        if (bus_we_i) mem_d[bus_waddr_i] = bus_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign bus_rdata_o = mem_q[bus_raddr_i];
    assign tap_rdata_o = mem_q[tap_addr_i];

    AST_BUS_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_we_i |=> mem_q[$past(bus_waddr_i)] == $past(bus_wdata_i)); // R4
endmodule

// File: rtl/i2c_port_fsm.sv
module i2c_port_fsm
    import i2c_regport_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ADDR = 7'b1001010
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_lvl_i,
    input  logic              sda_rise_i,
    input  logic              sda_fall_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [PTR_W-1:0]  rd_addr_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sda_oe_o
);
    localparam logic [CNT_W-1:0] BITS_CNT = CNT_W'(BYTE_W);

    port_regs_t r_d, r_q;
    logic start_w, stop_w, load_rd;

    assign start_w = sda_fall_i & scl_lvl_i;
    assign stop_w  = sda_rise_i & scl_lvl_i;

    always_comb begin
        r_d     = r_q;
        wr_en_o = 1'b0;
        load_rd = 1'b0;
        if (stop_w) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
            r_d.cnt   = '0;
        end else if (start_w) begin
            r_d.state = ST_ADDR;
            r_d.oe    = 1'b0;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise_i && r_q.cnt != BITS_CNT) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_lvl_i};
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end else if (scl_fall_i && r_q.cnt == BITS_CNT) begin
                        r_d.cnt   = '0;
                        r_d.oe    = 1'b1;
                        r_d.state = ST_ACK;
                        r_d.after = ST_WDATA;
                        if (r_q.state == ST_ADDR) begin
                            if (r_q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                                r_d.after = r_q.sh[0] ? ST_RDATA : ST_PTR;
                            end else begin
                                r_d.oe    = 1'b0;
                                r_d.state = ST_SKIP;
                            end
                        end else if (r_q.state == ST_PTR) begin
                            r_d.ptr  = r_q.sh[PTR_W-1:0];
                            r_d.incr = r_q.sh[BYTE_W-1];
                        end else begin
                            wr_en_o = 1'b1;
                            if (r_q.incr) r_d.ptr = r_q.ptr + PTR_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        if (r_q.after == ST_RDATA) begin
                            load_rd = 1'b1;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = r_q.after;
                            r_d.cnt   = '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall_i) begin
                        if (r_q.cnt == BITS_CNT) begin
                            r_d.oe    = 1'b0;
                            r_d.nack  = 1'b0;
                            r_d.state = ST_RACK;
                        end else begin
                            r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe  = ~r_q.sh[BYTE_W-2];
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        r_d.nack = sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (r_q.nack) r_d.state = ST_SKIP;
                        else          load_rd   = 1'b1;
                    end
                end
                default: ;
            endcase
            if (load_rd) begin
                r_d.sh    = rd_data_i;
                r_d.oe    = ~rd_data_i[BYTE_W-1];
                r_d.cnt   = CNT_W'(1);
                r_d.state = ST_RDATA;
                if (r_q.incr) r_d.ptr = r_q.ptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= PORT_RST;
        else         r_q <= r_d;
    end

    assign rd_addr_o = r_q.ptr;
    assign wr_addr_o = r_q.ptr;
    assign wr_data_o = r_q.sh;
    assign sda_oe_o  = r_q.oe;

    AST_SKIP_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_SKIP) |-> !sda_oe_o); // R2
    AST_NOINCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && !r_q.incr) |=> (r_q.ptr == $past(r_q.ptr))); // R5
    AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && r_q.incr && (&r_q.ptr)) |=> (r_q.ptr == '0)); // R6
    AST_STOP_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_w |=> ($stable(r_q.ptr) && $stable(r_q.incr))); // R8
    AST_DRIVE_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_lvl_i)); // R9
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'b1001010
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              tap_we_i,
    input  logic [PTR_W-1:0]  tap_addr_i,
    input  logic [BYTE_W-1:0] tap_wdata_i,
    output logic [BYTE_W-1:0] tap_rdata_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_w, lvl_w, rise_w, fall_w;
    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .line_i (raw_w[g]),
            .lvl_o  (lvl_w[g]),
            .rise_o (rise_w[g]),
            .fall_o (fall_w[g])
        );
    end

    logic [PTR_W-1:0]  rd_addr_w, wr_addr_w;
    logic [BYTE_W-1:0] rd_data_w, wr_data_w;
    logic              wr_en_w;

    i2c_port_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_lvl_i  (lvl_w[0]),
        .scl_rise_i (rise_w[0]),
        .scl_fall_i (fall_w[0]),
        .sda_lvl_i  (lvl_w[1]),
        .sda_rise_i (rise_w[1]),
        .sda_fall_i (fall_w[1]),
        .rd_data_i  (rd_data_w),
        .rd_addr_o  (rd_addr_w),
        .wr_en_o    (wr_en_w),
        .wr_addr_o  (wr_addr_w),
        .wr_data_o  (wr_data_w),
        .sda_oe_o   (sda_oe_o)
    );

    i2c_reg_bank #(.AW(PTR_W), .DW(BYTE_W)) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_we_i    (wr_en_w),
        .bus_waddr_i (wr_addr_w),
        .bus_wdata_i (wr_data_w),
        .bus_raddr_i (rd_addr_w),
        .bus_rdata_o (rd_data_w),
        .tap_we_i    (tap_we_i),
        .tap_addr_i  (tap_addr_i),
        .tap_wdata_i (tap_wdata_i),
        .tap_rdata_o (tap_rdata_o)
    );
endmodule

// File: tb/i2c_regport_tb_top.sv
module i2c_regport_tb_top;
    localparam int DEV = 7'b1001010;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       sda_oe;
    logic       tap_we = 1'b0;
    logic [6:0] tap_addr = '0;
    logic [7:0] tap_wdata = '0;
    logic [7:0] tap_rdata;
    wire        sda_bus = host_sda & ~sda_oe;

    always #4 clk_i = ~clk_i;

    i2c_regport dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .tap_we_i    (tap_we),
        .tap_addr_i  (tap_addr),
        .tap_wdata_i (tap_wdata),
        .tap_rdata_o (tap_rdata)
    );

    int checks = 0;
    int fails = 0;
    bit exp_oe = 1'b0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int hi_cnt = 0;
    int mem [128];
    int m_ptr = 0;
    int m_incr = 0;
    int wq [$];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of the drive enable against the model's expectation
    always begin
        @(posedge clk_i);
        #2;
        if (!rst_ni || !scl) hi_cnt = 0;
        else                 hi_cnt++;
        if (mon_en && hi_cnt >= 4) chk(sda_oe == exp_oe, "R9 drive during SCL high", sda_oe, exp_oe);
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic bus_start();
        exp_oe = 1'b0;
        host_sda = 1'b1; tick(10);
        scl = 1'b1;      tick(10);
        host_sda = 1'b0; tick(10);
        scl = 1'b0;      tick(10);
    endtask

    task automatic bus_stop();
        exp_oe = 1'b0;
        host_sda = 1'b0; tick(10);
        scl = 1'b1;      tick(10);
        host_sda = 1'b1; tick(20);
    endtask

    task automatic clk_bit(bit v, bit eoe, output bit seen);
        host_sda = v;
        exp_oe = eoe;
        tick(10);
        scl = 1'b1; tick(10);
        seen = sda_bus;
        tick(10);
        scl = 1'b0; tick(10);
    endtask

    task automatic send_byte(int b, bit acked, string req);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, s);
        clk_bit(1'b1, acked, s);
        chk(s == !acked, req, s, !acked);
    endtask

    task automatic recv_byte(int exp, bit host_ack, string req);
        bit s;
        int got = 0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, !exp[i], s);
            got = (got << 1) | int'(s);
        end
        chk(got == exp, req, got, exp);
        clk_bit(!host_ack, 1'b0, s);
    endtask

    task automatic do_write(int addr7, int ptrb, bit match);
        bus_start();
        send_byte((addr7 << 1), match, "R1 write address ack");
        send_byte(ptrb, match, "R3 pointer byte ack");
        if (match) begin
            m_ptr = ptrb & 127;
            m_incr = (ptrb >> 7) & 1;
        end
        foreach (wq[k]) begin
            send_byte(wq[k], match, "R4 data byte ack");
            if (match) begin
                mem[m_ptr] = wq[k];
                if (m_incr != 0) m_ptr = (m_ptr + 1) % 128;
            end
        end
    endtask

    task automatic do_read(int n, string req);
        bus_start();
        send_byte((DEV << 1) | 1, 1'b1, "R1 read address ack");
        for (int k = 0; k < n; k++) begin
            int e = mem[m_ptr];
            if (m_incr != 0) m_ptr = (m_ptr + 1) % 128;
            recv_byte(e, k < n - 1, req);
        end
    endtask

    task automatic tap_wr(int a, int d);
        tap_addr = 7'(a); tap_wdata = 8'(d); tap_we = 1'b1;
        tick(1);
        tap_we = 1'b0;
    endtask

    task automatic tap_chk(int a, string req);
        tap_addr = 7'(a);
        tick(1);
        chk(tap_rdata == 8'(mem[a]), req, tap_rdata, mem[a]);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int a = 0; a < 128; a++) mem[a] = 0;
        tick(5);
        rst_ni = 1'b1;
        tick(5);
        // R10: reset state
        chk(sda_oe == 1'b0, "R10 SDA released after reset", sda_oe, 0);
        tap_chk(5, "R10 register cleared by reset");
        tap_chk(127, "R10 top register cleared by reset");
        mon_en = 1'b1;

        // R11: preload through the side port and read it back
        for (int a = 0; a < 128; a++) begin
            tap_wr(a, (a * 7 + 3) & 255);
            mem[a] = (a * 7 + 3) & 255;
        end
        tap_chk(0, "R11 side port readback");
        tap_chk(77, "R11 side port readback");

        // R10: pointer starts at 0 with auto-increment off
        do_read(2, "R10 read at reset pointer");
        bus_stop();

        // R3 R4: write three bytes from 0x10 with auto-increment
        wq = {32'hA1, 32'hA2, 32'hA3};
        do_write(DEV, 32'h90, 1'b1);
        bus_stop();
        tap_chk(16, "R4 first byte stored");
        tap_chk(18, "R4 third byte stored");

        // R7: read continues at X+n; R8: NACK ends it
        do_read(2, "R7 read from advanced pointer");
        send_byte(32'hFF, 1'b0, "R8 released after NACK");
        bus_stop();

        // R5: auto-increment off keeps the pointer fixed
        wq = {32'h55, 32'h66};
        do_write(DEV, 32'h20, 1'b1);
        bus_stop();
        tap_chk(32, "R5 last byte wins at fixed pointer");
        tap_chk(33, "R5 next register untouched");

        // R6: wrap from 127 to 0
        wq = {32'hC1, 32'hC2, 32'hC3};
        do_write(DEV, 32'hFE, 1'b1);
        bus_stop();
        tap_chk(127, "R6 byte at top register");
        tap_chk(0, "R6 byte wrapped to register 0");
        do_read(1, "R6 read after wrap");
        bus_stop();

        // R2: other address is ignored
        wq = {32'h11, 32'h22};
        do_write(7'b1001011, 32'h85, 1'b0);
        bus_stop();
        tap_chk(5, "R2 register unchanged by foreign address");
        tap_chk(6, "R2 register unchanged by foreign address");

        // R8: pointer persists across the stop
        do_read(1, "R8 pointer kept across stop");
        bus_stop();

        // R7 R8: repeated start between write and read
        wq = {32'h3C};
        do_write(DEV, 32'hC0, 1'b1);
        do_read(3, "R7 read after repeated start");
        bus_stop();

        // R11: full bank comparison through the side port
        begin
            int bad = 0;
            int first = -1;
            for (int a = 0; a < 128; a++) begin
                tap_addr = 7'(a);
                tick(1);
                if (tap_rdata != 8'(mem[a])) begin
                    bad++;
                    if (first < 0) first = a;
                end
            end
            chk(bad == 0, "R11 full bank matches model", bad, 0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule